// File: doc/BRIEF.md
# Dual-Buffer Transmit Frame Controller

The controller holds two frame buffers, ping and pong, inside one 4 KB register window. Ping occupies the lower 2 KB and pong the upper 2 KB. Software writes frame bytes into a buffer as 32-bit little-endian words. It then writes the frame length and sets the busy bit in that buffer's status word. The sequencer streams the bytes out on a byte-wide valid/ready port, flags the final byte, and clears busy once the frame has left.

Setting busy together with the program bit makes the buffer carry an address load instead of a frame. The first six buffer bytes become the station address, and nothing is streamed. A level interrupt reports finished transmissions. It passes only when the transmit-complete enable and the global enable are both set.

The sequencer has four states:

| State | Meaning |
|---|---|
| `ST_IDLE` | No buffer is being served. |
| `ST_SEND` | The selected frame is being streamed. |
| `ST_LOAD` | Two buffer words are being copied into the station address. |
| `ST_DONE` | One cycle that ends the job and clears busy. |

Its transitions are:

| Transition | Taken when |
|---|---|
| idle to load | The selected buffer carries the program bit. |
| idle to done | The selected frame has zero length. |
| idle to send | Any other busy buffer is selected. |
| send to send | The frame is still streaming. |
| send to done | The last byte is accepted. |
| send to idle | Software cancels the active buffer. |
| load to done | The second word has been copied. |
| done to idle | Always. |

Top module: `txbuf_engine`

## Requirements
- R1: After reset, both status words and both length words read 0, `irq` is 0, `tx_valid` is 0 and `station_addr` is 0.
- R2: A frame of length N streams exactly N bytes in buffer order. Byte k is bits 8*(k%4)+7:8*(k%4) of word k/4, so a trailing partial word sends only the counted bytes. `tx_last` is high only on byte N-1. While `tx_ready` is low, data and last are held.
- R3: Status bit 0 is busy. Software sets it to launch a job. Hardware clears it in the second cycle after the last byte is accepted.
- R4: Ping data starts at byte offset 0x000 and pong data at 0x800. In each window the length word sits at 0x7F4 and holds 16 bits in bits 15:0, and the status word sits at 0x7FC. The global word sits at 0x7F8 of the ping window only; the pong window's 0x7F8 reads 0.
- R5: When both buffers are busy, the sequencer serves them in the order in which their busy bits were set.
- R6: A write that sets busy on a buffer that is already busy is ignored. The frame is sent once.
- R7: Writing status bits 0 and 1 together loads `station_addr` from buffer bytes 0..5, with byte 0 in bits 7:0. No byte is streamed, no interrupt is raised, and both bits read 0 afterwards.
- R8: Status bit 31 is stored and read back unchanged in both buffers, and it has no effect on operation.
- R9: Bit 3 of the ping status word enables the interrupt. When it is set, a finished transmission on either buffer sets a pending flag (bit 0 of the global word). `irq` equals pending AND global enable (bit 31 of the global word). Writing 1 to bit 0 of the global word clears pending.
- R10: Writing 0 to the status bit 0 of a busy buffer cancels the job. The buffer goes idle, streaming of that buffer stops, and no interrupt is raised.
- R11: A zero-length frame streams nothing but still clears busy. A length above the buffer capacity (4*BUF_WORDS bytes) streams only the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register/buffer write strobe |
| wr_addr | input | 12 | Write byte address (bit 11 selects pong) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Loaded station address |
| irq | output | 1 | Transmit-complete interrupt level |

## Verification
The bench checks frames whose length is not a multiple of four. A design with the byte lanes reversed, or one that sends whole words, produces wrong bytes or extra bytes. It launches pong before ping while the sink stalls, re-launches a busy buffer, and cancels both buffers mid-frame. Wrong drain order, a duplicated frame, or stray bytes after a cancel would each surface in the scoreboard. Address loads are checked for the exact 48-bit value and for silence on the stream and the interrupt. The interrupt is checked with the global enable off and on, so a design that ignores either gate or fails to clear pending on write-one is caught. Zero-length and over-capacity frames catch a sequencer that hangs or runs past the buffer.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_LOAD,
        ST_DONE
    } seq_state_t;

    // word offsets inside a 2 KB buffer window (byte offsets >> 2)
    localparam logic [8:0] WOFF_LEN  = 9'h1FD;  // 0x7F4
    localparam logic [8:0] WOFF_GLB  = 9'h1FE;  // 0x7F8
    localparam logic [8:0] WOFF_STAT = 9'h1FF;  // 0x7FC

    localparam int SB_BUSY = 0;
    localparam int SB_PROG = 1;
    localparam int SB_IE   = 3;
    localparam int SB_FLAG = 31;
    localparam int GB_PEND = 0;
    localparam int GB_GIE  = 31;

endpackage

// File: rtl/txbuf_ram.sv
module txbuf_ram #(
    parameter int BUF_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic                         wbuf,
    input  logic [$clog2(BUF_WORDS)-1:0] widx,
    input  logic [31:0]                  wdata,
    input  logic                         abuf,
    input  logic [$clog2(BUF_WORDS)-1:0] aidx,
    output logic [31:0]                  adata,
    input  logic                         bbuf,
    input  logic [$clog2(BUF_WORDS)-1:0] bidx,
    output logic [31:0]                  bdata
);

    logic [1:0][31:0] word_a;
    logic [1:0][31:0] word_b;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [31:0] mem [BUF_WORDS];

        always_ff @(posedge clk) begin
            if (we && (wbuf == 1'(g))) begin
                mem[widx] <= wdata;
            end
        end

        assign word_a[g] = mem[aidx];
        assign word_b[g] = mem[bidx];
    end

    assign adata = word_a[abuf];
    assign bdata = word_b[bbuf];

endmodule

// File: rtl/txbuf_regs.sv
module txbuf_regs
    import txbuf_pkg::*;
#(
    parameter int BUF_WORDS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [11:0]      wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [11:0]      rd_addr,
    input  logic [31:0]      ram_word,
    input  logic             done,
    input  logic             done_buf,
    output logic             ram_we,
    output logic [31:0]      rd_data,
    output logic [1:0]       busy,
    output logic [1:0]       prog,
    output logic [1:0][15:0] len,
    output logic             older,
    output logic             irq
);

    localparam logic [8:0] WORDS9 = 9'(BUF_WORDS);

    logic [1:0] flag;
    logic       ie;
    logic       gie;
    logic       pending;

    logic       wsel;
    logic [8:0] widx;
    logic       rsel;
    logic [8:0] ridx;
    logic       wr_len;
    logic       wr_glb;
    logic       wr_stat;

    assign wsel    = wr_addr[11];
    assign widx    = wr_addr[10:2];
    assign rsel    = rd_addr[11];
    assign ridx    = rd_addr[10:2];
    assign ram_we  = wr_en && (widx < WOFF_LEN) && (widx < WORDS9);
    assign wr_len  = wr_en && (widx == WOFF_LEN);
    assign wr_glb  = wr_en && (widx == WOFF_GLB) && !wsel;
    assign wr_stat = wr_en && (widx == WOFF_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= '0;
            prog    <= '0;
            flag    <= '0;
            len     <= '0;
            ie      <= 1'b0;
            gie     <= 1'b0;
            pending <= 1'b0;
            older   <= 1'b0;
        end else begin
            if (wr_len) begin
                len[wsel] <= wr_data[15:0];
            end
            if (wr_glb) begin
                gie <= wr_data[GB_GIE];
                if (wr_data[GB_PEND]) begin
                    pending <= 1'b0;
                end
            end
            if (wr_stat) begin
                flag[wsel] <= wr_data[SB_FLAG];
                if (!wsel) begin
                    ie <= wr_data[SB_IE];
                end
                if (!busy[wsel]) begin
                    busy[wsel] <= wr_data[SB_BUSY];
                    prog[wsel] <= wr_data[SB_BUSY] & wr_data[SB_PROG];
                    if (wr_data[SB_BUSY]) begin
                        older <= busy[~wsel] ? ~wsel : wsel;
                    end
                end else if (!wr_data[SB_BUSY]) begin
                    busy[wsel] <= 1'b0;
                    prog[wsel] <= 1'b0;
                end
            end
            if (done && busy[done_buf]) begin
                busy[done_buf] <= 1'b0;
                prog[done_buf] <= 1'b0;
                if (!prog[done_buf] && ie) begin
                    pending <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (ridx < WOFF_LEN) begin
                rd_data <= (ridx < WORDS9) ? ram_word : 32'h0;
            end else if (ridx == WOFF_LEN) begin
                rd_data <= {16'h0, len[rsel]};
            end else if (ridx == WOFF_GLB) begin
                rd_data <= rsel ? 32'h0 : {gie, 30'h0, pending};
            end else begin
                rd_data <= {flag[rsel], 27'h0, ie & ~rsel, 1'b0, prog[rsel], busy[rsel]};
            end
        end
    end

    assign irq = gie & pending;

    logic unused_bits;
    assign unused_bits = ^{wr_data[30:16], wr_data[2], wr_addr[1:0], rd_addr[1:0]};

endmodule

// File: rtl/txbuf_seq.sv
module txbuf_seq
    import txbuf_pkg::*;
#(
    parameter int BUF_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   busy,
    input  logic [1:0]                   prog,
    input  logic [1:0][15:0]             len,
    input  logic                         older,
    input  logic                         tx_ready,
    input  logic [31:0]                  word,
    output logic                         rbuf,
    output logic [$clog2(BUF_WORDS)-1:0] ridx,
    output logic                         tx_valid,
    output logic [7:0]                   tx_data,
    output logic                         tx_last,
    output logic                         done,
    output logic                         done_buf,
    output logic [47:0]                  station_addr
);

    localparam int AW  = $clog2(BUF_WORDS);
    localparam int CAP = BUF_WORDS * 4;
    localparam int CW  = AW + 3;

    seq_state_t    state;
    seq_state_t    nxt;
    logic          act;
    logic          pick;
    logic [CW-1:0] cnt;
    logic [CW-1:0] eff_act;
    logic [CW-1:0] eff_pick;

    function automatic logic [CW-1:0] clamp_len(input logic [15:0] l);
        return (l > 16'(CAP)) ? CW'(CAP) : l[CW-1:0];
    endfunction

    assign pick     = (busy == 2'b11) ? older : busy[1];
    assign eff_act  = clamp_len(len[act]);
    assign eff_pick = clamp_len(len[pick]);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (|busy) begin
                    if (prog[pick])          nxt = ST_LOAD;
                    else if (eff_pick == '0) nxt = ST_DONE;
                    else                     nxt = ST_SEND;
                end
            end
            ST_SEND: begin
                if (!busy[act])              nxt = ST_IDLE;
                else if (tx_ready && tx_last) nxt = ST_DONE;
            end
            ST_LOAD: begin
                if (cnt[0]) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act          <= 1'b0;
            cnt          <= '0;
            station_addr <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    act <= pick;
                    cnt <= '0;
                end
                ST_SEND: begin
                    if (tx_valid && tx_ready) cnt <= cnt + 1'b1;
                end
                ST_LOAD: begin
                    if (!cnt[0]) station_addr[31:0]  <= word;
                    else         station_addr[47:32] <= word[15:0];
                    cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tx_valid = (state == ST_SEND) && busy[act];
        tx_last  = tx_valid && (cnt == eff_act - 1'b1);
        tx_data  = word[8*cnt[1:0] +: 8];
        done     = (state == ST_DONE);
        done_buf = act;
        rbuf     = act;
        ridx     = (state == ST_LOAD) ? cnt[AW-1:0] : cnt[AW+1:2];
    end

endmodule

// File: rtl/txbuf_engine.sv
module txbuf_engine
    import txbuf_pkg::*;
#(
    parameter int BUF_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [11:0] rd_addr,
    output logic [31:0] rd_data,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_last,
    output logic [47:0] station_addr,
    output logic        irq
);

    localparam int AW = $clog2(BUF_WORDS);

    logic             ram_we;
    logic [31:0]      bus_word;
    logic [31:0]      eng_word;
    logic             eng_buf;
    logic [AW-1:0]    eng_idx;
    logic [1:0]       busy_w;
    logic [1:0]       prog_w;
    logic [1:0][15:0] len_w;
    logic             older_w;
    logic             done_w;
    logic             done_buf_w;

    txbuf_ram #(.BUF_WORDS(BUF_WORDS)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .wbuf  (wr_addr[11]),
        .widx  (wr_addr[AW+1:2]),
        .wdata (wr_data),
        .abuf  (rd_addr[11]),
        .aidx  (rd_addr[AW+1:2]),
        .adata (bus_word),
        .bbuf  (eng_buf),
        .bidx  (eng_idx),
        .bdata (eng_word)
    );

    txbuf_regs #(.BUF_WORDS(BUF_WORDS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .ram_word (bus_word),
        .done     (done_w),
        .done_buf (done_buf_w),
        .ram_we   (ram_we),
        .rd_data  (rd_data),
        .busy     (busy_w),
        .prog     (prog_w),
        .len      (len_w),
        .older    (older_w),
        .irq      (irq)
    );

    txbuf_seq #(.BUF_WORDS(BUF_WORDS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy_w),
        .prog         (prog_w),
        .len          (len_w),
        .older        (older_w),
        .tx_ready     (tx_ready),
        .word         (eng_word),
        .rbuf         (eng_buf),
        .ridx         (eng_idx),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .done         (done_w),
        .done_buf     (done_buf_w),
        .station_addr (station_addr)
    );

endmodule

// File: rtl/txbuf_chk.sv
module txbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_last,
    input logic       irq,
    input logic [1:0] busy,
    input logic [1:0] prog,
    input logic       done
);

    // R2
    last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R2
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_en) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R3
    busy_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy[0]) || $rose(busy[1])) |-> $past(wr_en));

    // R7
    prog_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(prog & ~busy)));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wr_en) || $past(done)));

    // R10
    stream_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (|busy));

endmodule

bind txbuf_engine txbuf_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .irq      (irq),
    .busy     (busy_w),
    .prog     (prog_w),
    .done     (done_w)
);

// File: tb/test_txbuf_engine.sv
module test_txbuf_engine;

    localparam int BUF_WORDS = 64;
    localparam int CAP       = BUF_WORDS * 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_last;
    logic [47:0] station_addr;
    logic        irq;

    always #4 clk = ~clk;

    txbuf_engine #(.BUF_WORDS(BUF_WORDS)) i_txbuf_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
        .station_addr(station_addr), .irq(irq)
    );

    int         total = 0;
    int         bad = 0;
    int         stray = 0;
    int         ready_mode = 0;
    logic       tog = 1'b0;
    logic [8:0] exp_q[$];
    logic [8:0] got;
    logic [8:0] want;

    // sink ready pattern, changed shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tog = ~tog;
            tx_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? tog : 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            total++;
            got = {tx_last, tx_data};
            if (exp_q.size() == 0) begin
                stray++;
                bad++;
                $display("FAIL R2 unexpected byte act=%0h exp=none", got);
            end else begin
                want = exp_q.pop_front();
                if (got !== want) begin
                    bad++;
                    $display("FAIL R2 stream byte {last,data} act=%0h exp=%0h", got, want);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [11:0] base(input int b);
        return (b != 0) ? 12'h800 : 12'h000;
    endfunction

    task automatic fill(input int b, input int n, input logic [7:0] seed);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] v;
            for (int i = 0; i < 4; i++) v[8*i +: 8] = seed + 8'(4 * w + i);
            bus_wr(base(b) + 12'(4 * w), v);
        end
        bus_wr(base(b) + 12'h7F4, 32'(n));
    endtask

    task automatic expect_frame(input int n, input logic [7:0] seed);
        int m;
        m = (n > CAP) ? CAP : n;
        for (int k = 0; k < m; k++) exp_q.push_back({(k == m - 1), seed + 8'(k)});
    endtask

    task automatic wait_idle(input int b, output logic [31:0] st);
        for (int i = 0; i < 3000; i++) begin
            bus_rd(base(b) + 12'h7FC, st);
            if (!st[0]) break;
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        int          s0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(12'h7FC, d);  chk(d == 0, "R1 ping status", d, 0);
        bus_rd(12'hFFC, d);  chk(d == 0, "R1 pong status", d, 0);
        bus_rd(12'h7F4, d);  chk(d == 0, "R1 ping length", d, 0);
        chk(irq == 0 && tx_valid == 0, "R1 irq/valid", {irq, tx_valid}, 0);
        chk(station_addr == 0, "R1 station", station_addr, 0);

        // R4 address map
        bus_wr(12'h7F4, 32'hFFFF0ABC);
        bus_rd(12'h7F4, d);  chk(d == 32'h0ABC, "R4 ping length", d, 32'h0ABC);
        bus_wr(12'hFF4, 32'h00000123);
        bus_rd(12'hFF4, d);  chk(d == 32'h0123, "R4 pong length", d, 32'h0123);
        bus_rd(12'h7F4, d);  chk(d == 32'h0ABC, "R4 ping length kept", d, 32'h0ABC);
        bus_wr(12'hFF8, 32'h80000000);
        bus_rd(12'hFF8, d);  chk(d == 0, "R4 pong global slot", d, 0);
        bus_wr(12'h804, 32'hDEADBEEF);
        bus_rd(12'h804, d);  chk(d == 32'hDEADBEEF, "R4 pong data word", d, 32'hDEADBEEF);

        // R2 R3 ping, 11 bytes, no backpressure
        ready_mode = 0;
        fill(0, 11, 8'h10);
        expect_frame(11, 8'h10);
        bus_wr(12'h7FC, 32'h1);
        wait_idle(0, d);
        chk(d[0] == 0, "R3 busy cleared", d, 0);
        chk(exp_q.size() == 0, "R2 frame complete", exp_q.size(), 0);

        // R2 pong, 13 bytes, backpressure
        ready_mode = 1;
        fill(1, 13, 8'h30);
        expect_frame(13, 8'h30);
        bus_wr(12'hFFC, 32'h1);
        wait_idle(1, d);
        chk(d[0] == 0, "R3 pong busy cleared", d, 0);
        chk(exp_q.size() == 0, "R2 backpressured frame", exp_q.size(), 0);

        // R5 ordering: pong set before ping
        ready_mode = 2;
        fill(0, 5, 8'h40);
        fill(1, 7, 8'h80);
        bus_wr(12'hFFC, 32'h1);
        expect_frame(7, 8'h80);
        bus_wr(12'h7FC, 32'h1);
        expect_frame(5, 8'h40);
        bus_rd(12'h7FC, d);
        bus_rd(12'hFFC, d2);
        chk(d[0] && d2[0], "R5 both busy", {d[0], d2[0]}, 2'b11);
        ready_mode = 1;
        wait_idle(1, d);
        wait_idle(0, d);
        settle();
        chk(exp_q.size() == 0, "R5 drain order", exp_q.size(), 0);

        // R6 re-launch of a busy buffer is ignored
        s0 = stray;
        ready_mode = 2;
        fill(0, 4, 8'hA0);
        expect_frame(4, 8'hA0);
        bus_wr(12'h7FC, 32'h1);
        bus_wr(12'h7FC, 32'h1);
        bus_rd(12'h7FC, d);
        chk(d[0] == 1, "R6 still busy", d, 1);
        ready_mode = 0;
        wait_idle(0, d);
        settle();
        chk(exp_q.size() == 0 && stray == s0, "R6 sent once", stray - s0, 0);

        // R9 interrupt gating and clearing
        bus_wr(12'h7F8, 32'h80000000);
        bus_wr(12'h7FC, 32'h8);
        fill(0, 6, 8'h50);
        expect_frame(6, 8'h50);
        bus_wr(12'h7FC, 32'h9);
        wait_idle(0, d);
        @(negedge clk);
        chk(irq == 1, "R9 irq raised", irq, 1);
        bus_rd(12'h7F8, d);
        chk(d == 32'h80000001, "R9 global word", d, 32'h80000001);
        bus_wr(12'h7F8, 32'h80000001);
        chk(irq == 0, "R9 pending cleared", irq, 0);
        bus_wr(12'h7F8, 32'h0);
        fill(1, 3, 8'h60);
        expect_frame(3, 8'h60);
        bus_wr(12'hFFC, 32'h1);
        wait_idle(1, d);
        @(negedge clk);
        chk(irq == 0, "R9 global enable off", irq, 0);
        bus_rd(12'h7F8, d);
        chk(d == 32'h1, "R9 pending held", d, 1);
        bus_wr(12'h7F8, 32'h80000000);
        chk(irq == 1, "R9 enable releases irq", irq, 1);
        bus_wr(12'h7F8, 32'h80000001);
        chk(irq == 0, "R9 cleared again", irq, 0);

        // R7 station address load
        s0 = stray;
        bus_wr(12'h800, 32'h33221100);
        bus_wr(12'h804, 32'h77665544);
        bus_wr(12'hFFC, 32'h3);
        wait_idle(1, d);
        settle();
        chk(d[1:0] == 0, "R7 bits clear", d[1:0], 0);
        chk(station_addr == 48'h554433221100, "R7 station", station_addr, 48'h554433221100);
        chk(irq == 0 && stray == s0, "R7 no irq no bytes", {irq, 32'(stray - s0)}, 0);

        // R8 scratch flag
        bus_wr(12'hFFC, 32'h80000000);
        bus_rd(12'hFFC, d);
        chk(d == 32'h80000000, "R8 flag stored", d, 32'h80000000);
        fill(1, 2, 8'h70);
        expect_frame(2, 8'h70);
        bus_wr(12'hFFC, 32'h80000001);
        wait_idle(1, d);
        chk(d == 32'h80000000 && exp_q.size() == 0, "R8 flag kept after send", d, 32'h80000000);
        bus_wr(12'h7F8, 32'h80000001);

        // R10 cancel both buffers mid-frame
        s0 = stray;
        ready_mode = 2;
        fill(0, 6, 8'h90);
        fill(1, 6, 8'hB0);
        bus_wr(12'h7FC, 32'h9);
        bus_wr(12'hFFC, 32'h1);
        bus_wr(12'h7FC, 32'h8);
        bus_wr(12'hFFC, 32'h0);
        ready_mode = 0;
        settle();
        bus_rd(12'h7FC, d);
        bus_rd(12'hFFC, d2);
        chk(d[0] == 0 && d2[0] == 0, "R10 both idle", {d[0], d2[0]}, 0);
        chk(stray == s0 && irq == 0, "R10 no bytes no irq", {irq, 32'(stray - s0)}, 0);

        // R11 zero length and over-capacity length
        bus_wr(12'h7FC, 32'h0);
        s0 = stray;
        bus_wr(12'h7F4, 32'h0);
        bus_wr(12'h7FC, 32'h1);
        wait_idle(0, d);
        settle();
        chk(d[0] == 0 && stray == s0, "R11 zero length", stray - s0, 0);
        ready_mode = 1;
        fill(1, 300, 8'h05);
        expect_frame(300, 8'h05);
        bus_wr(12'hFFC, 32'h1);
        wait_idle(1, d);
        settle();
        chk(d[0] == 0 && exp_q.size() == 0 && stray == s0, "R11 clamp to capacity",
            exp_q.size() + (stray - s0), 0);

        summary();
        $finish;
    end

endmodule